// File: doc/BRIEF.md
# Latched bidirectional bus transceiver

This block moves a word between two ports, A and B, in either direction. Each direction owns a storage register and three active-low controls: a chip enable, a latch enable and an output enable. The chip enable of a direction must be low both to load that direction's register from its source port and to drive the opposite port. With chip enable and latch enable both low, the register follows its source. Raising either of them freezes the word last taken. With chip enable and output enable both low, the destination port is driven with the stored word. Otherwise that port is left undriven.

The block is clocked, so the register is updated at rising clock edges. Each port is split into an input bus, an output bus and an active-high drive flag, so the core needs no internal tri-state logic. A pad wrapper can combine these into real bidirectional pins. The parameter `BYPASS` chooses how a transparent register is seen at the destination port. With `BYPASS=1`, a transparent register passes its source straight through in the same cycle. With `BYPASS=0`, the destination port only ever shows the registered word.

Reset is asynchronous and active low, and its release is synchronised to the clock. While reset is active, both ports are undriven and both registers are cleared.

Top module: `latched_xcvr`

## Requirements
- R1: While rst_n is low, a_oe and b_oe are 0. A reset clears both stored words to 0x00. After rst_n has been high for three rising edges, a direction whose chip and output enables are low and whose latch enable is high shows 0x00.
- R2: At a rising clk edge with ce_ab_n=0 and le_ab_n=0, the A-to-B register stores a_in.
- R3: At a rising clk edge with ce_ab_n=1 or le_ab_n=1, the A-to-B register keeps its word whatever a_in carries. A change on a_in during such cycles never shows on b_out.
- R4: Out of reset, b_oe is 1 when ce_ab_n=0 and oe_ab_n=0. b_out then carries the A-to-B stored word, or the pass-through value of R6.
- R5: b_oe is 0 whenever ce_ab_n=1 or oe_ab_n=1, whatever le_ab_n and a_in are.
- R6: With BYPASS=1, while ce_ab_n=0 and le_ab_n=0, b_out equals a_in in the same cycle, before the next clock edge.
- R7: With BYPASS=0, b_out shows only the stored word. A new a_in reaches b_out only after the next rising edge at which ce_ab_n=0 and le_ab_n=0.
- R8: The B-to-A direction obeys R2 to R7 with ce_ba_n, le_ba_n and oe_ba_n, taking b_in and driving a_out and a_oe. Neither direction's controls or data affect the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Word arriving at port A |
| a_out | output | W | Word driven onto port A |
| a_oe | output | 1 | Port A drive flag, 1 = driven |
| b_in | input | W | Word arriving at port B |
| b_out | output | W | Word driven onto port B |
| b_oe | output | 1 | Port B drive flag, 1 = driven |
| ce_ab_n | input | 1 | A-to-B chip enable, active low |
| le_ab_n | input | 1 | A-to-B latch enable, active low |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| ce_ba_n | input | 1 | B-to-A chip enable, active low |
| le_ba_n | input | 1 | B-to-A latch enable, active low |
| oe_ba_n | input | 1 | B-to-A output enable, active low |

## Verification
The bench builds two copies with W=8 that share every input: one with BYPASS=1 and one with BYPASS=0. After each clock edge both copies must show the same word, since a held-transparent register equals its source there. Between edges the two copies are compared separately, which exposes the same-cycle pass-through of the first against the edge-delayed update of the second. The vector sequence holds one direction transparent while the other holds and drives, so that any cross-coupling between the two registers becomes visible.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Active-low control triple of one direction.
  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } lane_ctl_t;

  localparam int NDIR = 2;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n,
  output logic run_ok
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_int_n = sh_q[STAGES-1];
  // The raw reset also gates outputs so ports drop at once.
  assign run_ok    = sh_q[STAGES-1] & rst_n;

endmodule

// File: rtl/xcvr_lane_ctl.sv
module xcvr_lane_ctl
  import xcvr_pkg::*;
(
  input  lane_ctl_t ctl,
  input  logic      run_ok,
  output logic      load,
  output logic      drive
);

  always_comb begin
    load  = !ctl.ce_n && !ctl.le_n;
    drive = run_ok && !ctl.ce_n && !ctl.oe_n;
  end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit BYPASS = 1'b1
) (
  input  logic         clk,
  input  logic         rst_int_n,
  input  logic         run_ok,
  input  logic [W-1:0] src,
  input  lane_ctl_t    ctl,
  output logic [W-1:0] dout,
  output logic         drive
);

  logic         load;
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  xcvr_lane_ctl u_ctl (
    .ctl    (ctl),
    .run_ok (run_ok),
    .load   (load),
    .drive  (drive)
  );

  always_comb begin
    word_d = src;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      word_q <= '0;
    end else if (load) begin
      word_q <= word_d;
    end
  end

  generate
    if (BYPASS) begin : g_pass
      assign dout = load ? src : word_q;
    end else begin : g_reg
      assign dout = word_q;
    end
  endgenerate

endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr
  import xcvr_pkg::*;
#(
  parameter int W          = 8,
  parameter bit BYPASS     = 1'b1,
  parameter int RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         ce_ab_n,
  input  logic         le_ab_n,
  input  logic         oe_ab_n,
  input  logic         ce_ba_n,
  input  logic         le_ba_n,
  input  logic         oe_ba_n
);

  logic         rst_int_n;
  logic         run_ok;
  lane_ctl_t    ctl_w [NDIR];
  logic [W-1:0] src_w [NDIR];
  logic [W-1:0] dout_w[NDIR];
  logic         drv_w [NDIR];

  xcvr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n),
    .run_ok    (run_ok)
  );

  // Lane 0 carries A to B, lane 1 carries B to A.
  assign ctl_w[0] = '{ce_n: ce_ab_n, le_n: le_ab_n, oe_n: oe_ab_n};
  assign ctl_w[1] = '{ce_n: ce_ba_n, le_n: le_ba_n, oe_n: oe_ba_n};
  assign src_w[0] = a_in;
  assign src_w[1] = b_in;

  generate
    for (genvar g = 0; g < NDIR; g++) begin : g_dir
      xcvr_lane #(.W(W), .BYPASS(BYPASS)) u_lane (
        .clk       (clk),
        .rst_int_n (rst_int_n),
        .run_ok    (run_ok),
        .src       (src_w[g]),
        .ctl       (ctl_w[g]),
        .dout      (dout_w[g]),
        .drive     (drv_w[g])
      );
    end
  endgenerate

  assign b_out = dout_w[0];
  assign b_oe  = drv_w[0];
  assign a_out = dout_w[1];
  assign a_oe  = drv_w[1];

endmodule

// File: rtl/latched_xcvr_chk.sv
module latched_xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic         ce_ab_n,
  input logic         le_ab_n,
  input logic         oe_ab_n,
  input logic         ce_ba_n,
  input logic         le_ba_n,
  input logic         oe_ba_n
);

  logic [1:0] cyc_q;
  logic       cyc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= 2'd0;
    end else if (cyc_q != 2'd3) begin
      cyc_q <= cyc_q + 2'd1;
    end
  end

  assign cyc_ok = (cyc_q == 2'd3);

  p_rst_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!a_oe && !b_oe));

  p_off_ab_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_ab_n || oe_ab_n) |-> !b_oe);

  p_off_ba_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_ba_n || oe_ba_n) |-> !a_oe);

  p_drive_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ok && !ce_ab_n && !oe_ab_n) |-> b_oe);

  p_drive_ba_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ok && !ce_ba_n && !oe_ba_n) |-> a_oe);

  p_hold_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ok && (ce_ab_n || le_ab_n) && $past(ce_ab_n || le_ab_n)) |-> $stable(b_out));

  p_hold_ba_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ok && (ce_ba_n || le_ba_n) && $past(ce_ba_n || le_ba_n)) |-> $stable(a_out));

  p_load_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ok && !ce_ab_n && !le_ab_n) |=>
      ((b_out == $past(a_in)) || (!ce_ab_n && !le_ab_n && (b_out == a_in))));

  p_load_ba_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_ok && !ce_ba_n && !le_ba_n) |=>
      ((a_out == $past(b_in)) || (!ce_ba_n && !le_ba_n && (a_out == b_in))));

endmodule

bind latched_xcvr latched_xcvr_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_in    (a_in),
  .a_out   (a_out),
  .a_oe    (a_oe),
  .b_in    (b_in),
  .b_out   (b_out),
  .b_oe    (b_oe),
  .ce_ab_n (ce_ab_n),
  .le_ab_n (le_ab_n),
  .oe_ab_n (oe_ab_n),
  .ce_ba_n (ce_ba_n),
  .le_ba_n (le_ba_n),
  .oe_ba_n (oe_ba_n)
);

// File: tb/latched_xcvr_tb_top.sv
`timescale 1ns/1ps
module latched_xcvr_tb_top;

  localparam int W  = 8;
  localparam int NV = 10;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic         ce_ab_n, le_ab_n, oe_ab_n, ce_ba_n, le_ba_n, oe_ba_n;
  logic [W-1:0] a_out, b_out, a_out_r, b_out_r;
  logic         a_oe, b_oe, a_oe_r, b_oe_r;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_ab, m_ba;

  // {ce_ab,le_ab,oe_ab, a_in, ce_ba,le_ba,oe_ba, b_in}
  localparam logic [21:0] VEC [NV] = '{
    {3'b000, 8'hA5, 3'b111, 8'h3C},
    {3'b010, 8'hFF, 3'b001, 8'h3C},
    {3'b010, 8'h00, 3'b010, 8'h77},
    {3'b100, 8'h12, 3'b011, 8'h88},
    {3'b010, 8'h34, 3'b010, 8'h99},
    {3'b000, 8'h5A, 3'b010, 8'hC3},
    {3'b001, 8'h6B, 3'b000, 8'hE1},
    {3'b010, 8'h00, 3'b100, 8'h11},
    {3'b010, 8'h00, 3'b010, 8'h22},
    {3'b110, 8'hF0, 3'b000, 8'h0F}
  };

  latched_xcvr #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
    .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n)
  );

  latched_xcvr #(.W(W), .BYPASS(1'b0)) dut_reg_i (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out_r), .a_oe(a_oe_r),
    .b_in(b_in), .b_out(b_out_r), .b_oe(b_oe_r),
    .ce_ab_n(ce_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
    .ce_ba_n(ce_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string tag,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One rising edge; model follows R2/R3/R8, then sample 1 ns later.
  task automatic tick();
    @(posedge clk);
    if (rst_n && !ce_ab_n && !le_ab_n) m_ab = a_in;
    if (rst_n && !ce_ba_n && !le_ba_n) m_ba = b_in;
    #1;
  endtask

  task automatic check_ports(input string tab, input string tba);
    logic eb, ea;
    eb = !ce_ab_n && !oe_ab_n;
    ea = !ce_ba_n && !oe_ba_n;
    chk(b_oe == eb && b_oe_r == eb, eb ? "R4 b_oe" : "R5 b_oe",
        {7'd0, b_oe}, {7'd0, eb});
    chk(a_oe == ea && a_oe_r == ea, "R8 a_oe", {7'd0, a_oe}, {7'd0, ea});
    if (eb) begin
      chk(b_out == m_ab, tab, b_out, m_ab);
      chk(b_out_r == m_ab, tab, b_out_r, m_ab);
    end
    if (ea) begin
      chk(a_out == m_ba, tba, a_out, m_ba);
      chk(a_out_r == m_ba, tba, a_out_r, m_ba);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    a_in = '0; b_in = '0;
    ce_ab_n = 1'b0; le_ab_n = 1'b1; oe_ab_n = 1'b0;
    ce_ba_n = 1'b0; le_ba_n = 1'b1; oe_ba_n = 1'b0;
    m_ab = '0; m_ba = '0;
    #1 rst_n = 1'b0;
    a_in = 8'h5F; b_in = 8'hF5;
    repeat (2) tick();
    // R1: no drive while reset is low
    chk(!a_oe && !b_oe && !a_oe_r && !b_oe_r, "R1 oe in reset",
        {6'd0, a_oe, b_oe}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) tick();
    // R1: cleared words visible once enabled
    check_ports("R1 b_out after reset", "R1 a_out after reset");

    // Vector walk: R2 R3 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      logic loaded;
      @(negedge clk);
      {ce_ab_n, le_ab_n, oe_ab_n, a_in, ce_ba_n, le_ba_n, oe_ba_n, b_in} = VEC[i];
      loaded = !ce_ab_n && !le_ab_n;
      tick();
      check_ports(loaded ? "R2 b_out" : "R3 b_out", "R8 a_out");
    end

    // R6 / R7: pass-through versus registered view, A to B
    @(negedge clk);
    ce_ab_n = 1'b0; le_ab_n = 1'b1; oe_ab_n = 1'b0; a_in = 8'h00;
    tick();
    @(negedge clk);
    le_ab_n = 1'b0; a_in = 8'hC7;
    #1;
    chk(b_out == 8'hC7, "R6 same-cycle pass", b_out, 8'hC7);
    chk(b_out_r == m_ab, "R7 registered before edge", b_out_r, m_ab);
    tick();
    chk(b_out == 8'hC7 && b_out_r == 8'hC7, "R7 after edge", b_out_r, 8'hC7);

    // R6 / R8: B to A pass-through
    @(negedge clk);
    ce_ba_n = 1'b0; le_ba_n = 1'b0; oe_ba_n = 1'b0; b_in = 8'h3E;
    #1;
    chk(a_out == 8'h3E, "R8 pass B to A", a_out, 8'h3E);
    tick();

    // R3: data ignored while chip enable is high
    @(negedge clk);
    le_ab_n = 1'b1;
    tick();
    @(negedge clk);
    ce_ab_n = 1'b1; le_ab_n = 1'b0; a_in = 8'h81;
    repeat (2) tick();
    chk(!b_oe, "R5 chip enable high", {7'd0, b_oe}, 8'h00);
    @(negedge clk);
    ce_ab_n = 1'b0; le_ab_n = 1'b1; a_in = 8'h42;
    tick();
    chk(b_out == 8'hC7 && b_out_r == 8'hC7, "R3 ignored a_in", b_out, 8'hC7);

    // R1: reset during operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!a_oe && !b_oe, "R1 async quiet", {6'd0, a_oe, b_oe}, 8'h00);
    m_ab = '0; m_ba = '0;
    le_ba_n = 1'b1;
    tick();
    @(negedge clk) rst_n = 1'b1;
    repeat (3) tick();
    chk(b_out == 8'h00 && a_out == 8'h00 && b_oe && a_oe, "R1 cleared",
        b_out | a_out, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule